// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block chooses which of four clock sources drives the system clock. Software writes a 2-bit request code. The controller moves the selection to that source through a fixed break-before-make handshake. A separate 2-bit status code tells which source is actually in use. The status code keeps its old value until the handshake has fully finished, so software reads the status field to learn when a switch is done.

Each source is modelled only by a ready flag, and the whole block runs in one reference clock domain. Hardware can take control and fall back to the internal RC oscillator in two cases: when the chip leaves a deep low-power state, and when the external crystal fails while it drives the system clock, either directly or as the reference of a PLL. A fallback also clears the request code, so a stale request does not send the clock straight back to the source that failed. The output is a one-hot select vector intended for a glitch-free clock multiplexer.

Top module: `clk_src_switch`

## Requirements
- R1: Source codes are 0 = internal RC oscillator, 1 = external crystal, 2 = PLL output P, 3 = digital PLL. Bit k of `sel_onehot_o` selects the source with code k.
- R2: After reset `req_code_o` = 0, `sts_code_o` = 0 and `sel_onehot_o` = 4'b0001.
- R3: A write through `req_wr_i` loads `req_code_i` into `req_code_o` on the next clock edge. `sts_code_o` keeps its old value until the switch completes.
- R4: A switch starts only when the ready flag of the requested source is high. While that flag is low, `sel_onehot_o` and `sts_code_o` stay unchanged. The switch starts on the first edge at which the flag is high.
- R5: A switch proceeds in three steps. First, `sel_onehot_o` is zero for OFF_CYC cycles. Next, it shows the new source for ON_CYC cycles while `sts_code_o` still shows the old code. Finally, `sts_code_o` takes the new code. With the defaults of 2 and 2, the status changes on the fifth edge after the write edge.
- R6: `sel_onehot_o` never has more than one bit set. It is never zero for more than OFF_CYC consecutive cycles.
- R7: A pulse on `lp_exit_i` clears the request to 0 on the next edge and switches the system clock back to code 0.
- R8: A pulse on `xtal_fail_i` while code 1 is active, or is the target of a switch in progress, forces the same fallback as R7.
- R9: A pulse on `xtal_fail_i` while code 2 or 3 is in use forces the fallback only if `pll_xtal_ref_i` is high. Otherwise it is ignored, and the request and selection are kept.
- R10: A pulse on `xtal_fail_i` while code 0 is in use and no switch is running leaves the request, status and selection unchanged.
- R11: A request written while a switch is running is held. Once the running switch completes, the controller acts on the latest held request.
- R12: A fallback takes priority over a write in the same cycle. A fallback during a switch redirects that switch to code 0 without making the zero gap of the select vector longer than OFF_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_wr_i | input | 1 | Request write strobe |
| req_code_i | input | 2 | Requested source code |
| src_rdy_i | input | 4 | Ready flag of each source, indexed by code |
| lp_exit_i | input | 1 | Exit from deep low-power state (event) |
| xtal_fail_i | input | 1 | Crystal failure detected (event) |
| pll_xtal_ref_i | input | 1 | High when the crystal is the PLL reference |
| sel_onehot_o | output | 4 | One-hot select vector for the clock multiplexer |
| sts_code_o | output | 2 | Code of the source currently in use |
| req_code_o | output | 2 | Current request code |

## Verification
Assertions check the following on every cycle:
- The select vector has at most one bit set.
- The select vector is never zero for more than OFF_CYC cycles in a row, counted by a checker counter.
- The status code changes only after the select vector has already shown the new source.
- A fallback always clears the request code on the next edge.
- A switch never starts toward a source that is not ready.

The directed scenarios show the following:
- The exact edge on which each step of the handshake happens.
- That crystal failures are ignored when the crystal is not in use.
- That a request written during a switch is held until the switch ends.
- That a fallback redirects a switch already in flight.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
    localparam int unsigned NSRC = 4;
    localparam int unsigned CODE_W = $clog2(NSRC);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [NSRC-1:0]   sel_t;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_GAP  = 2'd1,
        SW_ON   = 2'd2
    } sw_state_e;

    localparam code_t CODE_RC   = code_t'(0);
    localparam code_t CODE_XTAL = code_t'(1);

    function automatic sel_t code2sel(input code_t c);
        sel_t s;
        s = '0;
        s[c] = 1'b1;
        return s;
    endfunction

    // Code 1 uses the crystal directly; codes 2 and 3 use it through a PLL.
    function automatic logic uses_xtal(input code_t c, input logic pll_ref);
        return (c == CODE_XTAL) || (c[CODE_W-1] && pll_ref);
    endfunction
endpackage

// File: rtl/clksw_fault.sv
module clksw_fault
    import clksw_pkg::*;
(
    input  logic  lp_exit_i,
    input  logic  xtal_fail_i,
    input  logic  pll_xtal_ref_i,
    input  code_t sts_i,
    input  code_t tgt_i,
    input  logic  busy_i,
    output logic  force_o
);
    logic xtal_in_use;

    always_comb begin
        xtal_in_use = uses_xtal(sts_i, pll_xtal_ref_i)
                    || (busy_i && uses_xtal(tgt_i, pll_xtal_ref_i));
        force_o = lp_exit_i || (xtal_fail_i && xtal_in_use);
    end
endmodule

// File: rtl/clksw_req.sv
module clksw_req
    import clksw_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  wr_i,
    input  code_t code_i,
    input  logic  force_i,
    output code_t req_o
);
    typedef struct packed {
        code_t req;
    } req_reg_t;

    req_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (force_i) begin
            r_d.req = CODE_RC;
        end else if (wr_i) begin
            r_d.req = code_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{req: CODE_RC};
        else         r_q <= r_d;
    end

    assign req_o = r_q.req;

    // R7
    force_clears_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_i |=> (req_o == CODE_RC));

    // R3
    write_loads_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !force_i) |=> (req_o == $past(code_i)));
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
    import clksw_pkg::*;
#(
    parameter int unsigned OFF_CYC = 2,
    parameter int unsigned ON_CYC  = 2
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  code_t     req_i,
    input  sel_t      rdy_i,
    input  logic      force_i,
    output sel_t      sel_o,
    output code_t     sts_o,
    output code_t     tgt_o,
    output logic      busy_o
);
    localparam int unsigned MAXC = (OFF_CYC > ON_CYC) ? OFF_CYC : ON_CYC;
    localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CNT_W-1:0] OFF_LD = CNT_W'(OFF_CYC - 1);
    localparam logic [CNT_W-1:0] ON_LD  = CNT_W'(ON_CYC - 1);

    typedef struct packed {
        sw_state_e        st;
        logic [CNT_W-1:0] cnt;
        code_t            tgt;
        code_t            sts;
        sel_t             sel;
    } seq_reg_t;

    seq_reg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SW_IDLE: begin
                if (force_i) begin
                    if (s_q.sts != CODE_RC) begin
                        s_d.st  = SW_GAP;
                        s_d.cnt = OFF_LD;
                        s_d.tgt = CODE_RC;
                        s_d.sel = '0;
                    end
                end else if ((req_i != s_q.sts) && rdy_i[req_i]) begin
                    s_d.st  = SW_GAP;
                    s_d.cnt = OFF_LD;
                    s_d.tgt = req_i;
                    s_d.sel = '0;
                end
            end
            SW_GAP: begin
                // Redirect keeps the running gap count.
                if (force_i) s_d.tgt = CODE_RC;
                if (s_q.cnt == '0) begin
                    s_d.st  = SW_ON;
                    s_d.cnt = ON_LD;
                    s_d.sel = code2sel(s_d.tgt);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SW_ON: begin
                if (force_i && (s_q.tgt != CODE_RC)) begin
                    s_d.st  = SW_GAP;
                    s_d.cnt = OFF_LD;
                    s_d.tgt = CODE_RC;
                    s_d.sel = '0;
                end else if (s_q.cnt == '0) begin
                    s_d.st  = SW_IDLE;
                    s_d.sts = s_q.tgt;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: SW_IDLE, cnt: '0, tgt: CODE_RC, sts: CODE_RC,
                     sel: code2sel(CODE_RC)};
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_o  = s_q.sel;
    assign sts_o  = s_q.sts;
    assign tgt_o  = s_q.tgt;
    assign busy_o = (s_q.st != SW_IDLE);

    // Checker: length of the current zero run on the select vector.
    logic [CNT_W+1:0] zrun_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   zrun_q <= '0;
        else if (s_d.sel == '0)        zrun_q <= zrun_q + 1'b1;
        else                           zrun_q <= '0;
    end

    // R6
    sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(sel_o));

    // R6
    zero_gap_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zrun_q <= (CNT_W+2)'(OFF_CYC));

    // R5
    sts_after_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts_o != $past(sts_o)) |-> ($past(sel_o) == code2sel(sts_o)));

    // R4
    start_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((s_q.st == SW_IDLE) && !force_i && (req_i != sts_o) && !rdy_i[req_i])
            |=> (sel_o == $past(sel_o)));
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
    import clksw_pkg::*;
#(
    parameter int unsigned OFF_CYC = 2,
    parameter int unsigned ON_CYC  = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_wr_i,
    input  logic [CODE_W-1:0]   req_code_i,
    input  logic [NSRC-1:0]     src_rdy_i,
    input  logic                lp_exit_i,
    input  logic                xtal_fail_i,
    input  logic                pll_xtal_ref_i,
    output logic [NSRC-1:0]     sel_onehot_o,
    output logic [CODE_W-1:0]   sts_code_o,
    output logic [CODE_W-1:0]   req_code_o
);
    code_t req_q;
    code_t sts;
    code_t tgt;
    logic  busy;
    logic  force_fb;

    clksw_fault u_fault (
        .lp_exit_i      (lp_exit_i),
        .xtal_fail_i    (xtal_fail_i),
        .pll_xtal_ref_i (pll_xtal_ref_i),
        .sts_i          (sts),
        .tgt_i          (tgt),
        .busy_i         (busy),
        .force_o        (force_fb)
    );

    clksw_req u_req (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (req_wr_i),
        .code_i  (req_code_i),
        .force_i (force_fb),
        .req_o   (req_q)
    );

    clksw_seq #(
        .OFF_CYC (OFF_CYC),
        .ON_CYC  (ON_CYC)
    ) u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (req_q),
        .rdy_i   (src_rdy_i),
        .force_i (force_fb),
        .sel_o   (sel_onehot_o),
        .sts_o   (sts),
        .tgt_o   (tgt),
        .busy_o  (busy)
    );

    assign sts_code_o = sts;
    assign req_code_o = req_q;

    // R12
    fallback_to_rc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (force_fb && busy) |=> (tgt == CODE_RC));
endmodule

// File: tb/tb_clk_src_switch.sv
module tb_clk_src_switch;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_wr = 1'b0;
    logic [1:0] req_code = 2'd0;
    logic [3:0] src_rdy = 4'b1111;
    logic       lp_exit = 1'b0;
    logic       xtal_fail = 1'b0;
    logic       pll_ref = 1'b0;
    logic [3:0] sel;
    logic [1:0] sts;
    logic [1:0] req;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_src_switch dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .req_wr_i       (req_wr),
        .req_code_i     (req_code),
        .src_rdy_i      (src_rdy),
        .lp_exit_i      (lp_exit),
        .xtal_fail_i    (xtal_fail),
        .pll_xtal_ref_i (pll_ref),
        .sel_onehot_o   (sel),
        .sts_code_o     (sts),
        .req_code_o     (req)
    );

    function automatic logic [3:0] oh(input logic [1:0] c);
        return 4'b0001 << c;
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Called just after the edge that enters the zero gap (R5, R6).
    task automatic follow_gap(input string tag, input logic [1:0] old_c, input logic [1:0] new_c);
        chk({tag, " R5 gap1 sel"}, sel, 4'b0000);
        chk({tag, " R3 gap1 sts"}, {2'b0, sts}, {2'b0, old_c});
        @(negedge clk);
        chk({tag, " R6 gap2 sel"}, sel, 4'b0000);
        @(negedge clk);
        chk({tag, " R1 on1 sel"}, sel, oh(new_c));
        chk({tag, " R5 on1 sts"}, {2'b0, sts}, {2'b0, old_c});
        @(negedge clk);
        chk({tag, " R5 on2 sts"}, {2'b0, sts}, {2'b0, old_c});
        @(negedge clk);
        chk({tag, " R5 done sts"}, {2'b0, sts}, {2'b0, new_c});
        chk({tag, " R5 done sel"}, sel, oh(new_c));
    endtask

    task automatic wr(input logic [1:0] c);
        @(negedge clk);
        req_wr = 1'b1;
        req_code = c;
        @(negedge clk);
        req_wr = 1'b0;
        chk("R3 req loaded", {2'b0, req}, {2'b0, c});
    endtask

    task automatic switch_to(input string tag, input logic [1:0] old_c, input logic [1:0] new_c);
        wr(new_c);
        @(negedge clk);
        follow_gap(tag, old_c, new_c);
    endtask

    task automatic pulse_fail_expect_fb(input string tag, input logic [1:0] old_c);
        @(negedge clk);
        xtal_fail = 1'b1;
        @(negedge clk);
        xtal_fail = 1'b0;
        chk({tag, " req cleared"}, {2'b0, req}, 4'd0);
        follow_gap(tag, old_c, 2'd0);
    endtask

    task automatic hold_check(input string tag, input logic [1:0] c_req, input logic [1:0] c_sts);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk({tag, " req"}, {2'b0, req}, {2'b0, c_req});
            chk({tag, " sts"}, {2'b0, sts}, {2'b0, c_sts});
            chk({tag, " sel"}, sel, oh(c_sts));
        end
    endtask

    task automatic t_reset();
        chk("R2 reset sel", sel, 4'b0001);
        chk("R2 reset sts", {2'b0, sts}, 4'd0);
        chk("R2 reset req", {2'b0, req}, 4'd0);
    endtask

    task automatic t_basic();
        switch_to("R1 basic 0to1", 2'd0, 2'd1);
        switch_to("R1 basic 1to3", 2'd1, 2'd3);
    endtask

    task automatic t_ready();
        src_rdy[2] = 1'b0;
        wr(2'd2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R4 not ready sel", sel, 4'b1000);
            chk("R4 not ready sts", {2'b0, sts}, 4'd3);
        end
        src_rdy[2] = 1'b1;
        @(negedge clk);
        follow_gap("R4 ready rose", 2'd3, 2'd2);
    endtask

    task automatic t_pll_fail();
        pll_ref = 1'b0;
        @(negedge clk);
        xtal_fail = 1'b1;
        @(negedge clk);
        xtal_fail = 1'b0;
        hold_check("R9 no xtal ref ignored", 2'd2, 2'd2);
        pll_ref = 1'b1;
        pulse_fail_expect_fb("R9 xtal ref fallback", 2'd2);
    endtask

    task automatic t_rc_fail();
        pll_ref = 1'b1;
        @(negedge clk);
        xtal_fail = 1'b1;
        @(negedge clk);
        xtal_fail = 1'b0;
        hold_check("R10 rc ignored", 2'd0, 2'd0);
        pll_ref = 1'b0;
    endtask

    task automatic t_direct_fail();
        switch_to("R8 setup", 2'd0, 2'd1);
        pulse_fail_expect_fb("R8 direct xtal", 2'd1);
    endtask

    task automatic t_queue();
        wr(2'd1);
        req_wr = 1'b1;
        req_code = 2'd3;
        @(negedge clk);
        req_wr = 1'b0;
        chk("R11 queued req", {2'b0, req}, 4'd3);
        chk("R11 gap sel", sel, 4'b0000);
        @(negedge clk);
        @(negedge clk);
        chk("R11 first target sel", sel, oh(2'd1));
        @(negedge clk);
        @(negedge clk);
        chk("R11 first done sts", {2'b0, sts}, 4'd1);
        @(negedge clk);
        follow_gap("R11 queued switch", 2'd1, 2'd3);
    endtask

    task automatic t_lp_exit();
        @(negedge clk);
        lp_exit = 1'b1;
        @(negedge clk);
        lp_exit = 1'b0;
        chk("R7 req cleared", {2'b0, req}, 4'd0);
        follow_gap("R7 lp exit", 2'd3, 2'd0);
    endtask

    task automatic t_same_cycle();
        switch_to("R12 setup", 2'd0, 2'd3);
        @(negedge clk);
        req_wr = 1'b1;
        req_code = 2'd2;
        lp_exit = 1'b1;
        @(negedge clk);
        req_wr = 1'b0;
        lp_exit = 1'b0;
        chk("R12 force beats write", {2'b0, req}, 4'd0);
        follow_gap("R12 same cycle", 2'd3, 2'd0);
    endtask

    task automatic t_abort();
        wr(2'd2);
        @(negedge clk);
        chk("R12 abort gap", sel, 4'b0000);
        @(negedge clk);
        @(negedge clk);
        chk("R12 abort on phase", sel, oh(2'd2));
        lp_exit = 1'b1;
        @(negedge clk);
        lp_exit = 1'b0;
        chk("R12 abort req", {2'b0, req}, 4'd0);
        follow_gap("R12 abort", 2'd0, 2'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_ready();
        t_pll_fail();
        t_rc_fail();
        t_direct_fail();
        t_queue();
        t_lp_exit();
        t_same_cycle();
        t_abort();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule